// File: doc/BRIEF.md
# Auxiliary Supply Power-Fail Qualifier

This block sits behind an analog comparator that reports whether an auxiliary supply is above its trip level. The raw comparator result is asynchronous and has no hysteresis, so every bit of noise rejection has to happen here. The block passes the raw level through a synchronizer chain. It then drives an active-low power-fail flag that follows the comparator only after the new level has been seen continuously for a qualification time.

The qualification time depends on the direction of the change. A recovery (fail flag going high) is accepted after `RISE_CYC` consecutive samples. A loss of supply (fail flag going low) needs `FALL_CYC` consecutive samples. The defaults correspond to the nominal 7 µs recovery and 20 µs loss delays at a 200 MHz clock. A crossing that reverts before its qualification time has elapsed leaves the flag untouched. After reset the flag reports a failure until a qualified recovery is seen.

Top module: `pfg_filter`

## Requirements
- R1: While and after reset, `pfail_n` is 0 (failure), and it stays 0 until a recovery has been qualified.
- R2: When `supply_ok_raw` goes from 0 to 1 and is held for at least `RISE_CYC` sampling edges while `pfail_n` is 0, `pfail_n` goes to 1 exactly `RISE_CYC + 2` clock edges after the first edge that samples the new level. The 2 comes from the two-stage synchronizer.
- R3: When `supply_ok_raw` goes from 1 to 0 and is held for at least `FALL_CYC` sampling edges while `pfail_n` is 1, `pfail_n` goes to 0 exactly `FALL_CYC + 2` clock edges after the first edge that samples the new level.
- R4: A high excursion of `supply_ok_raw` that lasts at most `RISE_CYC - 1` sampling edges leaves `pfail_n` at 0.
- R5: A low excursion of `supply_ok_raw` that lasts at most `FALL_CYC - 1` sampling edges leaves `pfail_n` at 1.
- R6: Qualification is not cumulative. A single sample that agrees with the current `pfail_n` level discards all progress, and the next disagreeing run must again last the full qualification time.
- R7: Two successive changes of `pfail_n` are separated by at least `min(RISE_CYC, FALL_CYC)` clock edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_ok_raw | input | 1 | Asynchronous comparator result, 1 = auxiliary supply above threshold |
| pfail_n | output | 1 | Qualified power-fail flag, 0 = failure, 1 = supply good |

## Verification
The two events that can land on the same edge are the counter reaching its qualification limit and the synchronized input reverting to the current output level. Excursions lasting exactly the qualification time and one sample less are driven in both directions. The first must flip the output on the predicted edge and the second must leave it alone. The scoreboard also checks the gap between successive output changes against the shorter qualification time.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    typedef enum logic {
        LVL_FAIL = 1'b0,
        LVL_GOOD = 1'b1
    } level_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

    function automatic int min_of(input int a, input int b);
        return (a < b) ? a : b;
    endfunction

endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] sh_d;
    logic [STAGES-1:0] sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];
endmodule

// File: rtl/pfg_qualify.sv
module pfg_qualify
    import pfg_pkg::*;
#(
    parameter int RISE_CYC = 1400,
    parameter int FALL_CYC = 4000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic s_in,
    output logic level_out
);
    localparam int MAXC = max_of(RISE_CYC, FALL_CYC);
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] RISE_LIM = CW'(RISE_CYC - 1);
    localparam logic [CW-1:0] FALL_LIM = CW'(FALL_CYC - 1);

    typedef struct packed {
        level_e        state;
        logic [CW-1:0] cnt;
    } qual_t;

    qual_t nx_d;
    qual_t cur_q;
    logic [CW-1:0] lim;

    always_comb begin
        nx_d = cur_q;
        lim  = (cur_q.state == LVL_GOOD) ? FALL_LIM : RISE_LIM;
        if (s_in == cur_q.state) begin
            nx_d.cnt = '0;
        end else if (cur_q.cnt == lim) begin
            nx_d.state = level_e'(s_in);
            nx_d.cnt   = '0;
        end else begin
            nx_d.cnt = cur_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q.state <= LVL_FAIL;
            cur_q.cnt   <= '0;
        end else begin
            cur_q <= nx_d;
        end
    end

    assign level_out = cur_q.state;

    AST_RISE_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(level_out) |-> $past(s_in)); // R2
    AST_FALL_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(level_out) |-> !$past(s_in)); // R3
    AST_AGREE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (s_in == level_out) |=> $stable(level_out)); // R4
    AST_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.cnt < CW'(MAXC)); // R6
endmodule

// File: rtl/pfg_filter.sv
module pfg_filter
    import pfg_pkg::*;
#(
    parameter int RISE_CYC    = 1400,
    parameter int FALL_CYC    = 4000,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok_raw,
    output logic pfail_n
);
    localparam int MIN_DWELL = min_of(RISE_CYC, FALL_CYC);
    localparam int DW        = $clog2(MIN_DWELL + 1);

    logic ok_sync;

    pfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (supply_ok_raw),
        .dout  (ok_sync)
    );

    pfg_qualify #(.RISE_CYC(RISE_CYC), .FALL_CYC(FALL_CYC)) u_qual (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_in      (ok_sync),
        .level_out (pfail_n)
    );

    // dwell tracking used only by the spacing check below
    logic          prev_d, prev_q;
    logic [DW-1:0] dwell_d, dwell_q;
    logic          changed;

    always_comb begin
        changed = (pfail_n != prev_q);
        prev_d  = pfail_n;
        if (changed)                     dwell_d = DW'(1);
        else if (dwell_q == DW'(MIN_DWELL)) dwell_d = dwell_q;
        else                             dwell_d = dwell_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q  <= 1'b0;
            dwell_q <= '0;
        end else begin
            prev_q  <= prev_d;
            dwell_q <= dwell_d;
        end
    end

    AST_MIN_DWELL: assert property (@(posedge clk) disable iff (!rst_n)
        changed |-> (dwell_q >= DW'(MIN_DWELL))); // R7
    AST_RESET_FAIL: assert property (@(posedge clk)
        !rst_n |-> (pfail_n == 1'b0)); // R1
endmodule

// File: tb/pfg_filter_test.sv
module pfg_filter_test;
    localparam int RISE = 24;
    localparam int FALL = 60;
    localparam int MIN_GAP = (RISE < FALL) ? RISE : FALL;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok_raw = 1'b0;
    logic pfail_n;

    always #2.5 clk = ~clk;

    pfg_filter #(.RISE_CYC(RISE), .FALL_CYC(FALL), .SYNC_STAGES(2)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .supply_ok_raw (supply_ok_raw),
        .pfail_n       (pfail_n)
    );

    typedef struct {
        int    t;
        logic  v;
        string tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   failures = 0;
    int   edge_n = 0;
    logic exp_state = 1'b0;
    logic seen = 1'b0;
    int   last_change = -1;
    bit   done = 1'b0;

    always @(posedge clk) edge_n <= edge_n + 1;

    task automatic fail_msg(input string tag, input string what, input int act, input int exp);
        failures++;
        $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    endtask

    // Driver: apply level v for hold sampling edges; alternate levels between calls.
    task automatic drive(input logic v, input int hold, input string tag);
        int t0;
        int need;
        @(negedge clk);
        supply_ok_raw = v;
        t0 = edge_n;
        need = v ? RISE : FALL;
        if (v != exp_state && hold >= need) begin
            exp_t e;
            e.t = t0 + need + 2;
            e.v = v;
            e.tag = tag;
            exp_q.push_back(e);
            exp_state = v;
        end
        repeat (hold - 1) @(negedge clk);
    endtask

    task automatic expect_level(input string tag);
        @(negedge clk);
        checks++;
        if (exp_q.size() != 0)
            fail_msg(tag, "pending_items", exp_q.size(), 0);
        else if (pfail_n !== exp_state)
            fail_msg(tag, "pfail_n", int'(pfail_n), int'(exp_state));
    endtask

    // Monitor: every output change must match the next scoreboard item.
    always @(negedge clk) begin
        if (rst_n && !done && pfail_n !== seen) begin
            checks++;
            if (exp_q.size() == 0) begin
                fail_msg("R4/R5 unexpected", "change_at_edge", edge_n, -1);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (edge_n != e.t || pfail_n !== e.v)
                    fail_msg(e.tag, "edge", edge_n, e.t);
            end
            if (last_change >= 0) begin
                checks++;
                if (edge_n - last_change < MIN_GAP)
                    fail_msg("R7", "gap", edge_n - last_change, MIN_GAP);
            end
            last_change = edge_n;
            seen = pfail_n;
        end
    end

    task automatic finish_run;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    always @(posedge clk) begin
        if (edge_n > 150000 && !done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", edge_n, 150000);
            finish_run();
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        checks++;
        if (pfail_n !== 1'b0) fail_msg("R1", "reset_level", int'(pfail_n), 0);
        rst_n = 1'b1;
        expect_level("R1");

        // R4: high excursion one sample short of qualification
        drive(1'b1, RISE - 1, "R4");
        drive(1'b0, 10, "R4");
        expect_level("R4");
        expect_level("R1");

        // R2: exactly RISE samples qualifies
        drive(1'b1, RISE, "R2");
        // R5: low excursion one sample short
        drive(1'b0, FALL - 1, "R5");
        drive(1'b1, 30, "R5");
        expect_level("R5");

        // R3: exactly FALL samples qualifies
        drive(1'b0, FALL, "R3");
        drive(1'b1, 5, "R3");
        drive(1'b0, 20, "R3");
        expect_level("R3");

        // R6: interrupted run restarts the count
        drive(1'b1, RISE - 1, "R6");
        drive(1'b0, 1, "R6");
        drive(1'b1, RISE + 5, "R6");
        expect_level("R6");
        drive(1'b0, FALL - 2, "R6");
        drive(1'b1, 1, "R6");
        drive(1'b0, FALL + 10, "R6");
        expect_level("R6");

        // R4: burst of short high glitches while failed
        for (int i = 0; i < 10; i++) begin
            drive(1'b1, 3, "R4");
            drive(1'b0, 3, "R4");
        end
        expect_level("R4");

        // R2 long hold, then R5 burst of low glitches while good
        drive(1'b1, RISE + 40, "R2");
        for (int i = 0; i < 8; i++) begin
            drive(1'b0, 5, "R5");
            drive(1'b1, 5, "R5");
        end
        expect_level("R5");

        // R3 then R2 with long holds
        drive(1'b0, 200, "R3");
        drive(1'b1, 100, "R2");
        drive(1'b0, FALL + 20, "R3");
        expect_level("R3");

        repeat (20) @(negedge clk);
        checks++;
        if (exp_q.size() != 0) fail_msg("R2/R3 drain", "leftover", exp_q.size(), 0);
        finish_run();
    end
endmodule